// File: doc/BRIEF.md
# Register write command packer

The packer turns a stream of register write requests into the dword image of an instruction buffer held in a local RAM. Each request carries a 20-bit register offset, a 32-bit value and a flag that marks it as a write to an auto-increment (indexed) register. Plain writes become two-dword instructions. Indexed writes become a counted instruction. A run of indexed writes to the same register is merged into one instruction: each new value is appended and the count dword at the head of the instruction is rewritten.

Every instruction starts on an even dword index. An indexed instruction that ends on an odd position gets a zero dword behind it. A flush zero-fills the buffer up to the next 64-byte line and reports the padded length in bytes. A clear rewinds the buffer so it can be refilled. A registered read port lets the consumer fetch the image.

Top module: `cmd_packer`

## Requirements
- R1: A plain request (`req_indexed_i`=0) writes the value at the free position and the word `{8'h01, 4'hF, offset}` one dword above it. The free position then advances by 2, with no alignment first.
- R2: An indexed request that does not continue the open indexed instruction first rounds the free position up to an even index P. It writes 1 at P, `{8'h09, 4'h0, offset}` at P+1 and the value at P+2. The free position becomes P+3, and the instruction at P becomes the open one.
- R3: An indexed request with the same offset as the open instruction writes the value at the free position, writes the incremented count at the open instruction's first dword, and advances the free position by 1.
- R4: After any indexed request, if the new free position is odd, the dword at that position is written as zero.
- R5: A plain request closes the open indexed instruction. A later indexed request to the same offset starts a new instruction.
- R6: A request accepted while the free position is at or above the capacity (2^ADDR_W dwords) writes nothing and leaves the free position unchanged. It sets `overflow_o`, which stays high until a clear.
- R7: A flush zero-fills the dwords from the free position up to the next multiple of 16 dwords and leaves the free position unchanged. It then pulses `flush_done_o` for one cycle, with `tail_bytes_o` holding that padded length in bytes. Dwords at or beyond the boundary keep their contents.
- R8: `clear_i` sets the free position to 0, closes the open instruction and drops `overflow_o`. It does not erase the RAM.
- R9: After reset the free position is 0, `overflow_o` and `flush_done_o` are low and `req_ready_o` is high.
- R10: After a request is accepted, `req_ready_o` stays low for exactly as many cycles as dwords are written: 2 for plain, 4 for a new indexed instruction, 2 or 3 for a merge, and 0 for a dropped request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge if valid |
| req_indexed_i | input | 1 | Request targets an auto-increment register |
| req_offset_i | input | 20 | Register offset |
| req_value_i | input | 32 | Register value |
| flush_i | input | 1 | Pad buffer to a 64-byte line (taken when idle) |
| clear_i | input | 1 | Rewind the buffer |
| free_pos_o | output | ADDR_W+2 | Next free dword index |
| overflow_o | output | 1 | Sticky dropped-request flag |
| tail_bytes_o | output | ADDR_W+4 | Padded length in bytes from the last flush |
| flush_done_o | output | 1 | One-cycle pulse when the flush fill ends |
| rd_addr_i | input | ADDR_W | Image read address |
| rd_data_o | output | 32 | Image read data, one cycle after the address |

## Verification
`free_pos_o` and `overflow_o` take their new values at the edge that accepts the request. The RAM writes follow, one dword per edge, so `req_ready_o` comes back high on the edge after the last write. The bench counts the low `req_ready_o` cycles at falling edges to check R10, and it reads the image only once the block is idle again. Each read drives the address at a falling edge and samples the data at the next falling edge, which accounts for the registered read port. Flush completion is polled at falling edges until `flush_done_o` rises, and `tail_bytes_o` is sampled in that same cycle.

// File: rtl/cmd_packer_pkg.sv
package cmd_packer_pkg;
  localparam int OFF_W     = 20;
  localparam int DATA_W    = 32;
  localparam int MAX_SLOTS = 4;
  localparam int LINE_W    = 4;  // 16 dwords = 64 bytes

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL     = 4'hF;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_FILL} pk_state_e;

  function automatic logic [DATA_W-1:0] mk_cmd(input logic [7:0] op,
                                               input logic [3:0] be,
                                               input logic [OFF_W-1:0] off);
    return {op, be, off};
  endfunction
endpackage

// File: rtl/cmd_packer_ram.sv
module cmd_packer_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    rd_o <= mem_q[ra_i];
  end
endmodule

// File: rtl/cmd_packer_enc.sv
module cmd_packer_enc
  import cmd_packer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PTR_W  = ADDR_W + 2
) (
  input  logic [PTR_W-1:0]                       fp_i,
  input  logic                                   open_vld_i,
  input  logic [OFF_W-1:0]                       open_off_i,
  input  logic [PTR_W-1:0]                       open_start_i,
  input  logic [PTR_W-1:0]                       open_cnt_i,
  input  logic                                   indexed_i,
  input  logic [OFF_W-1:0]                       offset_i,
  input  logic [DATA_W-1:0]                      value_i,
  output logic [MAX_SLOTS-1:0][PTR_W-1:0]        slot_addr_o,
  output logic [MAX_SLOTS-1:0][DATA_W-1:0]       slot_data_o,
  output logic [2:0]                             slot_n_o,
  output logic [PTR_W-1:0]                       nxt_fp_o,
  output logic                                   nxt_open_vld_o,
  output logic [OFF_W-1:0]                       nxt_open_off_o,
  output logic [PTR_W-1:0]                       nxt_open_start_o,
  output logic [PTR_W-1:0]                       nxt_open_cnt_o
);
  logic [PTR_W-1:0] base_al;
  logic [PTR_W-1:0] cnt_inc;
  logic             hit;
  logic [PTR_W-1:0] fp_body;
  logic [2:0]       n_body;

  assign base_al = fp_i + PTR_W'(fp_i[0]);
  assign hit     = open_vld_i && (open_off_i == offset_i);
  assign cnt_inc = open_cnt_i + PTR_W'(1);

  always_comb begin
    slot_addr_o      = '0;
    slot_data_o      = '0;
    fp_body          = fp_i;
    n_body           = 3'd0;
    nxt_open_vld_o   = open_vld_i;
    nxt_open_off_o   = open_off_i;
    nxt_open_start_o = open_start_i;
    nxt_open_cnt_o   = open_cnt_i;
    if (!indexed_i) begin
      slot_addr_o[0] = fp_i;
      slot_data_o[0] = value_i;
      slot_addr_o[1] = fp_i + PTR_W'(1);
      slot_data_o[1] = mk_cmd(OP_DIRECT, BE_ALL, offset_i);
      fp_body        = fp_i + PTR_W'(2);
      n_body         = 3'd2;
      nxt_open_vld_o = 1'b0;
    end else if (!hit) begin
      slot_addr_o[0]   = base_al;
      slot_data_o[0]   = DATA_W'(1);
      slot_addr_o[1]   = base_al + PTR_W'(1);
      slot_data_o[1]   = mk_cmd(OP_INDEXED, 4'h0, offset_i);
      slot_addr_o[2]   = base_al + PTR_W'(2);
      slot_data_o[2]   = value_i;
      fp_body          = base_al + PTR_W'(3);
      n_body           = 3'd3;
      nxt_open_vld_o   = 1'b1;
      nxt_open_off_o   = offset_i;
      nxt_open_start_o = base_al;
      nxt_open_cnt_o   = PTR_W'(1);
    end else begin
      slot_addr_o[0] = fp_i;
      slot_data_o[0] = value_i;
      slot_addr_o[1] = open_start_i;
      slot_data_o[1] = DATA_W'(cnt_inc);
      fp_body        = fp_i + PTR_W'(1);
      n_body         = 3'd2;
      nxt_open_cnt_o = cnt_inc;
    end
    nxt_fp_o = fp_body;
    slot_n_o = n_body;
    // zero pad behind an odd-ending indexed instruction
    if (indexed_i && fp_body[0]) begin
      slot_addr_o[n_body[1:0]] = fp_body;
      slot_data_o[n_body[1:0]] = '0;
      slot_n_o                 = n_body + 3'd1;
    end
  end
endmodule

// File: rtl/cmd_packer_ctrl.sv
module cmd_packer_ctrl
  import cmd_packer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PTR_W  = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_indexed_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [DATA_W-1:0] req_value_i,
  input  logic              flush_i,
  input  logic              clear_i,
  output logic [PTR_W-1:0]  free_pos_o,
  output logic              overflow_o,
  output logic [PTR_W+1:0]  tail_bytes_o,
  output logic              flush_done_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] wa_o,
  output logic [DATA_W-1:0] wd_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LINE_DW = 1 << LINE_W;

  pk_state_e        state_q;
  logic [PTR_W-1:0] fp_q, open_start_q, open_cnt_q, tail_q, fill_ptr_q;
  logic             open_vld_q, ovf_q, done_q;
  logic [OFF_W-1:0] open_off_q;
  logic [MAX_SLOTS-1:0][PTR_W-1:0]  slot_addr_q;
  logic [MAX_SLOTS-1:0][DATA_W-1:0] slot_data_q;
  logic [2:0]       slot_n_q;
  logic [1:0]       idx_q;

  logic [MAX_SLOTS-1:0][PTR_W-1:0]  e_addr;
  logic [MAX_SLOTS-1:0][DATA_W-1:0] e_data;
  logic [2:0]       e_n;
  logic [PTR_W-1:0] e_fp, e_start, e_cnt;
  logic             e_vld;
  logic [OFF_W-1:0] e_off;

  logic             accept, flush_go, dropped, fill_act;
  logic [PTR_W-1:0] tail_nxt, cur_addr, fp_round;
  logic [DATA_W-1:0] cur_data;

  cmd_packer_enc #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_enc (
    .fp_i            (fp_q),
    .open_vld_i      (open_vld_q),
    .open_off_i      (open_off_q),
    .open_start_i    (open_start_q),
    .open_cnt_i      (open_cnt_q),
    .indexed_i       (req_indexed_i),
    .offset_i        (req_offset_i),
    .value_i         (req_value_i),
    .slot_addr_o     (e_addr),
    .slot_data_o     (e_data),
    .slot_n_o        (e_n),
    .nxt_fp_o        (e_fp),
    .nxt_open_vld_o  (e_vld),
    .nxt_open_off_o  (e_off),
    .nxt_open_start_o(e_start),
    .nxt_open_cnt_o  (e_cnt)
  );

  assign req_ready_o = (state_q == ST_IDLE) && !clear_i && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign flush_go    = (state_q == ST_IDLE) && flush_i && !clear_i;
  assign dropped     = fp_q >= PTR_W'(DEPTH);
  assign fp_round    = fp_q + PTR_W'(LINE_DW - 1);
  assign tail_nxt    = {fp_round[PTR_W-1:LINE_W], {LINE_W{1'b0}}};
  assign fill_act    = (state_q == ST_FILL) && (fill_ptr_q != tail_q);

  always_comb begin
    if (state_q == ST_EMIT) begin
      cur_addr = slot_addr_q[idx_q];
      cur_data = slot_data_q[idx_q];
    end else begin
      cur_addr = fill_ptr_q;
      cur_data = '0;
    end
  end

  // words past capacity are never stored
  assign we_o = !clear_i && (cur_addr < PTR_W'(DEPTH)) &&
                ((state_q == ST_EMIT) || fill_act);
  assign wa_o = cur_addr[ADDR_W-1:0];
  assign wd_o = cur_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fp_q         <= '0;
      open_vld_q   <= 1'b0;
      open_off_q   <= '0;
      open_start_q <= '0;
      open_cnt_q   <= '0;
      ovf_q        <= 1'b0;
      tail_q       <= '0;
      fill_ptr_q   <= '0;
      done_q       <= 1'b0;
      slot_addr_q  <= '0;
      slot_data_q  <= '0;
      slot_n_q     <= '0;
      idx_q        <= '0;
    end else begin
      done_q <= 1'b0;
      if (clear_i) begin
        state_q      <= ST_IDLE;
        fp_q         <= '0;
        open_vld_q   <= 1'b0;
        open_start_q <= '0;
        open_cnt_q   <= '0;
        ovf_q        <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (flush_go) begin
              tail_q     <= tail_nxt;
              fill_ptr_q <= fp_q;
              state_q    <= ST_FILL;
            end else if (accept) begin
              if (dropped) begin
                ovf_q <= 1'b1;
              end else begin
                slot_addr_q  <= e_addr;
                slot_data_q  <= e_data;
                slot_n_q     <= e_n;
                idx_q        <= '0;
                fp_q         <= e_fp;
                open_vld_q   <= e_vld;
                open_off_q   <= e_off;
                open_start_q <= e_start;
                open_cnt_q   <= e_cnt;
                state_q      <= ST_EMIT;
              end
            end
          end
          ST_EMIT: begin
            idx_q <= idx_q + 2'd1;
            if ({1'b0, idx_q} == slot_n_q - 3'd1) state_q <= ST_IDLE;
          end
          ST_FILL: begin
            if (fill_act) begin
              fill_ptr_q <= fill_ptr_q + PTR_W'(1);
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign free_pos_o   = fp_q;
  assign overflow_o   = ovf_q;
  assign tail_bytes_o = {tail_q, 2'b00};
  assign flush_done_o = done_q;
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmd_packer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PTR_W  = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_indexed_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [DATA_W-1:0] req_value_i,
  input  logic              flush_i,
  input  logic              clear_i,
  output logic [PTR_W-1:0]  free_pos_o,
  output logic              overflow_o,
  output logic [PTR_W+1:0]  tail_bytes_o,
  output logic              flush_done_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;

  cmd_packer_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_indexed_i(req_indexed_i),
    .req_offset_i (req_offset_i),
    .req_value_i  (req_value_i),
    .flush_i      (flush_i),
    .clear_i      (clear_i),
    .free_pos_o   (free_pos_o),
    .overflow_o   (overflow_o),
    .tail_bytes_o (tail_bytes_o),
    .flush_done_o (flush_done_o),
    .we_o         (we),
    .wa_o         (wa),
    .wd_o         (wd)
  );

  cmd_packer_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i(clk_i),
    .we_i (we),
    .wa_i (wa),
    .wd_i (wd),
    .ra_i (rd_addr_i),
    .rd_o (rd_data_o)
  );
endmodule

// File: rtl/cmd_packer_chk.sv
module cmd_packer_chk #(
  parameter int ADDR_W = 6,
  parameter int PTR_W  = ADDR_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             req_indexed_i,
  input logic             clear_i,
  input logic [PTR_W-1:0] free_pos_o,
  input logic             overflow_o,
  input logic [PTR_W+1:0] tail_bytes_o,
  input logic             flush_done_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic acc, room;
  assign acc  = req_valid_i && req_ready_o;
  assign room = free_pos_o < PTR_W'(DEPTH);

  // R1
  direct_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !req_indexed_i && room |=> free_pos_o == $past(free_pos_o) + PTR_W'(2));

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !room |=> (free_pos_o == $past(free_pos_o)) && overflow_o);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !clear_i |=> overflow_o);

  // R7
  tail_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> (tail_bytes_o[5:0] == 6'd0) &&
                     (tail_bytes_o >= {free_pos_o, 2'b00}));

  // R8
  clear_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (free_pos_o == '0) && !overflow_o);

  // R8
  fp_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> free_pos_o >= $past(free_pos_o));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && room |=> !req_ready_o);
endmodule

bind cmd_packer cmd_packer_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_indexed_i(req_indexed_i),
  .clear_i      (clear_i),
  .free_pos_o   (free_pos_o),
  .overflow_o   (overflow_o),
  .tail_bytes_o (tail_bytes_o),
  .flush_done_o (flush_done_o)
);

// File: tb/cmd_packer_bench.sv
module cmd_packer_bench;
  localparam int ADDR_W = 6;
  localparam int PTR_W  = ADDR_W + 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_indexed_i = 1'b0;
  logic [19:0]       req_offset_i = '0;
  logic [31:0]       req_value_i = '0;
  logic              flush_i = 1'b0;
  logic              clear_i = 1'b0;
  logic [PTR_W-1:0]  free_pos_o;
  logic              overflow_o;
  logic [PTR_W+1:0]  tail_bytes_o;
  logic              flush_done_o;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [31:0]       rd_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  cmd_packer #(.ADDR_W(ADDR_W)) u_cmd_packer (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic ix, input logic [19:0] off,
                      input logic [31:0] val, output int busy);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_indexed_i = ix; req_offset_i = off; req_value_i = val;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    busy = 0;
    while (!req_ready_o && busy < 20) begin busy++; @(negedge clk_i); end
  endtask

  task automatic rdw(input int a, output logic [31:0] d);
    @(negedge clk_i);
    rd_addr_i = ADDR_W'(a);
    @(posedge clk_i);
    @(negedge clk_i);
    d = rd_data_o;
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic do_flush();
    int n;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    flush_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    flush_i = 1'b0;
    n = 0;
    while (!flush_done_o && n < 100) begin n++; @(negedge clk_i); end
    chk("R7 done pulse", 32'(flush_done_o), 32'd1);
  endtask

  task automatic t_reset();
    chk("R9 free_pos", 32'(free_pos_o), 32'd0);
    chk("R9 overflow", 32'(overflow_o), 32'd0);
    chk("R9 ready", 32'(req_ready_o), 32'd1);
    chk("R9 done", 32'(flush_done_o), 32'd0);
  endtask

  task automatic t_direct();
    int b; logic [31:0] d;
    do_clear();
    send(1'b0, 20'h70180, 32'hDEADBEEF, b);
    chk("R10 plain busy", 32'(b), 32'd2);
    chk("R1 free_pos", 32'(free_pos_o), 32'd2);
    rdw(0, d); chk("R1 value word", d, 32'hDEADBEEF);
    rdw(1, d); chk("R1 cmd word", d, 32'h01F70180);
    send(1'b0, 20'h00004, 32'h11, b);
    rdw(2, d); chk("R1 second value", d, 32'h11);
    rdw(3, d); chk("R1 second cmd", d, 32'h01F00004);
    chk("R1 free_pos 4", 32'(free_pos_o), 32'd4);
  endtask

  task automatic t_indexed();
    int b; logic [31:0] d;
    do_clear();
    send(1'b1, 20'h60000, 32'hA1, b);
    chk("R10 new indexed busy", 32'(b), 32'd4);
    chk("R2 free_pos", 32'(free_pos_o), 32'd3);
    rdw(0, d); chk("R2 count", d, 32'd1);
    rdw(1, d); chk("R2 cmd", d, 32'h09060000);
    rdw(2, d); chk("R2 value", d, 32'hA1);
    rdw(3, d); chk("R4 pad", d, 32'd0);
    send(1'b1, 20'h60000, 32'hA2, b);
    chk("R10 merge even busy", 32'(b), 32'd2);
    chk("R3 free_pos", 32'(free_pos_o), 32'd4);
    rdw(3, d); chk("R3 appended", d, 32'hA2);
    rdw(0, d); chk("R3 count 2", d, 32'd2);
    send(1'b1, 20'h60000, 32'hA3, b);
    chk("R10 merge odd busy", 32'(b), 32'd3);
    rdw(4, d); chk("R3 appended 3", d, 32'hA3);
    rdw(5, d); chk("R4 pad 5", d, 32'd0);
    rdw(0, d); chk("R3 count 3", d, 32'd3);
  endtask

  task automatic t_close();
    int b; logic [31:0] d;
    // continues from fp=5 with the 0x60000 instruction open
    send(1'b0, 20'h00200, 32'hB0, b);
    chk("R1 unaligned fp", 32'(free_pos_o), 32'd7);
    rdw(5, d); chk("R1 odd placement", d, 32'hB0);
    send(1'b1, 20'h60000, 32'hC1, b);
    chk("R5 new instr fp", 32'(free_pos_o), 32'd11);
    rdw(8, d); chk("R5 new count at aligned", d, 32'd1);
    rdw(9, d); chk("R2 aligned cmd", d, 32'h09060000);
    rdw(10, d); chk("R2 aligned value", d, 32'hC1);
    rdw(0, d); chk("R5 old count kept", d, 32'd3);
  endtask

  task automatic t_flush();
    int b; logic [31:0] d;
    do_clear();
    for (int i = 0; i < 10; i++) send(1'b0, 20'h00010, 32'h5000 + 32'(i), b);
    do_clear();
    send(1'b0, 20'h00300, 32'hE0, b);
    do_flush();
    chk("R7 tail bytes", 32'(tail_bytes_o), 32'd64);
    chk("R7 fp kept", 32'(free_pos_o), 32'd2);
    for (int a = 2; a < 16; a++) begin
      rdw(a, d); chk("R7 zero fill", d, 32'd0);
    end
    rdw(16, d); chk("R7 past boundary kept", d, 32'h5008);
    do_clear();
    for (int i = 0; i < 8; i++) send(1'b0, 20'h00020, 32'h7000 + 32'(i), b);
    do_flush();
    chk("R7 aligned tail", 32'(tail_bytes_o), 32'd64);
    rdw(16, d); chk("R7 aligned no write", d, 32'h5008);
    send(1'b0, 20'h00020, 32'h9, b);
    send(1'b1, 20'h00040, 32'h9, b);
    do_flush();
    chk("R7 tail 128", 32'(tail_bytes_o), 32'd128);
  endtask

  task automatic t_overflow();
    int b; logic [31:0] d;
    do_clear();
    for (int i = 0; i < 32; i++) send(1'b0, 20'h00030, 32'h100 + 32'(i), b);
    chk("R6 full fp", 32'(free_pos_o), 32'd64);
    chk("R6 no ovf yet", 32'(overflow_o), 32'd0);
    send(1'b0, 20'h00031, 32'hFFFF, b);
    chk("R10 dropped busy", 32'(b), 32'd0);
    chk("R6 ovf set", 32'(overflow_o), 32'd1);
    chk("R6 fp held", 32'(free_pos_o), 32'd64);
    rdw(0, d); chk("R6 head intact", d, 32'h100);
    repeat (3) @(negedge clk_i);
    chk("R6 ovf sticky", 32'(overflow_o), 32'd1);
    do_clear();
    chk("R8 ovf cleared", 32'(overflow_o), 32'd0);
    chk("R8 fp cleared", 32'(free_pos_o), 32'd0);
  endtask

  task automatic t_clear_open();
    int b; logic [31:0] d;
    do_clear();
    send(1'b1, 20'h60000, 32'hD1, b);
    do_clear();
    send(1'b1, 20'h60000, 32'hD2, b);
    chk("R8 reopen fp", 32'(free_pos_o), 32'd3);
    rdw(0, d); chk("R8 reopen count", d, 32'd1);
    rdw(2, d); chk("R8 reopen value", d, 32'hD2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_direct();
    t_indexed();
    t_close();
    t_flush();
    t_overflow();
    t_clear_open();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule